// File: doc/BRIEF.md
# Programmable IDE PIO Cycle Timer

This block turns a single programmed-I/O request into one timed IDE bus cycle. The cycle has three phases in a fixed sequence: an address setup phase with no strobe, an active phase with either the read strobe or the write strobe asserted, and a recovery phase with both strobes low. The block stays busy until recovery has fully elapsed, so that the drive always sees the programmed minimum recovery between commands.

Each request names a drive (0 to 3), a direction, and whether it targets the 16-bit data register or some other task-file register. Data-register cycles take their active and recovery lengths from the per-drive timing set. All other task-file cycles take them from a shared command timing byte. Address setup always comes from the selected timing set. A mapping input decides which drives share which of the two timing sets. Each 2-bit or 4-bit code decodes into a clock count through a nonlinear table. A drive-ready input can stretch the active phase for as long as the drive needs.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset, `busy`, `rd_strobe` and `wr_strobe` are low.
- R2: A request accepted on a clock edge makes `busy` high from the next cycle on. The setup phase lasts a number of clocks set by bits [7:6] of the selected set's address byte. The code decodes as follows: 00 gives 3 clocks, 01 gives 1, 10 gives 2 and 11 gives 4. No strobe is asserted during setup.
- R3: The active phase lasts the decoded active count, with the strobe matching the direction (`rd_strobe` for reads, `wr_strobe` for writes). Active codes decode as follows: 0000 gives 16 clocks, 0001 and 0010 give 2, and any other code n gives n. For data cycles the read active code is bits [7:4] of the set's rw byte and the write active code is bits [3:0]. For command cycles the code is `cmd_timing[7:4]`.
- R4: Data-cycle recovery uses bits [3:0] of the set's address byte. Code 0000 gives 16 clocks. Codes 0001 and 0010 give 4 clocks on reads and 5 on writes. Codes 0011 to 1111 give 5 to 17 clocks.
- R5: Command-cycle recovery uses `cmd_timing[3:0]`: 0000 gives 16 clocks and any other code n gives n.
- R6: `req_data` = 1 selects the data timing (R3 data fields, R4). `req_data` = 0 selects the command timing (R3 command field, R5). Setup comes from the set in both cases.
- R7: With `map_by_pair` = 0, drives 0 and 2 use set 0 and drives 1 and 3 use set 1. With `map_by_pair` = 1, drives 0 and 1 use set 0 and drives 2 and 3 use set 1.
- R8: While `iordy` is low at the end of the active count, the strobe stays asserted. Recovery starts only on the first clock edge at which the count has elapsed and `iordy` is high.
- R9: A request presented while `busy` is high is ignored, so no further cycle follows it. A new request is accepted only once recovery has fully elapsed.
- R10: `rd_strobe` and `wr_strobe` are never high together, a strobe is high only while `busy` is high, and `cyc_drive` is stable throughout a cycle and equals the accepted drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request a cycle; taken when not busy |
| req_drive | input | 2 | Target drive number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_data | input | 1 | 1 = data register, 0 = other task-file register |
| map_by_pair | input | 1 | Drive-to-timing-set mapping select |
| cmd_timing | input | 8 | [7:4] command active code, [3:0] command recovery code |
| set0_addr | input | 8 | Set 0: [7:6] setup code, [3:0] data recovery code |
| set0_rw | input | 8 | Set 0: [7:4] read active code, [3:0] write active code |
| set1_addr | input | 8 | Set 1: same layout as set0_addr |
| set1_rw | input | 8 | Set 1: same layout as set0_rw |
| iordy | input | 1 | Drive ready; low stretches the active phase |
| busy | output | 1 | High from acceptance to the end of recovery |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| cyc_drive | output | 2 | Drive addressed by the current cycle |

## Verification
The assertions check the following on every cycle: the two strobes are exclusive, a strobe appears only while busy, the drive output is held steady within a cycle, the phase counter stays in range, and the active phase holds while the drive is not ready. The decoded lengths of each phase can only be shown by the bench's scenarios, which measure them against tables it computes itself. The same holds for the choice between data and command timing, the two drive-to-set mappings, and the refusal of requests that arrive during a cycle.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;
   localparam int CNT_W = 5;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SETUP,
      PH_ACTIVE,
      PH_RECOVER
   } phase_t;

   typedef struct packed {
      logic [CNT_W-1:0] setup;
      logic [CNT_W-1:0] active;
      logic [CNT_W-1:0] recover;
   } cyc_times_t;

   function automatic logic [CNT_W-1:0] dec_setup(input logic [1:0] code);
      case (code)
         2'b00:   return CNT_W'(3);
         2'b01:   return CNT_W'(1);
         2'b10:   return CNT_W'(2);
         default: return CNT_W'(4);
      endcase
   endfunction

   function automatic logic [CNT_W-1:0] dec_active(input logic [3:0] code);
      if (code == 4'd0)      return CNT_W'(16);
      else if (code <= 4'd2) return CNT_W'(2);
      else                   return CNT_W'(code);
   endfunction

   function automatic logic [CNT_W-1:0] dec_cmd_rec(input logic [3:0] code);
      return (code == 4'd0) ? CNT_W'(16) : CNT_W'(code);
   endfunction

   function automatic logic [CNT_W-1:0] dec_data_rec(input logic [3:0] code,
                                                     input logic       wr);
      if (code == 4'd0)      return CNT_W'(16);
      else if (code <= 4'd2) return wr ? CNT_W'(5) : CNT_W'(4);
      else                   return CNT_W'(code) + CNT_W'(2);
   endfunction
endpackage

// File: rtl/pio_timing_select.sv
module pio_timing_select
   import pio_timer_pkg::*;
#(
   parameter int DRIVES = 4,
   parameter int SETS   = 2,
   localparam int DRV_W = $clog2(DRIVES)
)(
   input  logic [DRV_W-1:0] drive,
   input  logic             write,
   input  logic             data_port,
   input  logic             map_by_pair,
   input  logic [7:0]       cmd_timing,
   input  logic [7:0]       set_addr [SETS],
   input  logic [7:0]       set_rw   [SETS],
   output cyc_times_t       times
);
   generate
      if (SETS != 2) begin : g_bad_sets
         $error("pio_timing_select supports exactly two timing sets");
      end
   endgenerate

   logic       set_idx;
   logic [7:0] addr_b;
   logic [7:0] rw_b;

   // mapping select: split by odd/even drive or by drive pair
   assign set_idx = map_by_pair ? drive[DRV_W-1] : drive[0];
   assign addr_b  = set_addr[set_idx];
   assign rw_b    = set_rw[set_idx];

   always_comb begin
      times.setup = dec_setup(addr_b[7:6]);
      if (data_port) begin
         times.active  = dec_active(write ? rw_b[3:0] : rw_b[7:4]);
         times.recover = dec_data_rec(addr_b[3:0], write);
      end else begin
         times.active  = dec_active(cmd_timing[7:4]);
         times.recover = dec_cmd_rec(cmd_timing[3:0]);
      end
   end
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
   import pio_timer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  cyc_times_t times,
   input  logic       ready,
   output phase_t     phase,
   output logic       busy
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] act_q;
   logic [CNT_W-1:0] rec_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         act_q <= '0;
         rec_q <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (start) begin
               phase <= PH_SETUP;
               cnt   <= times.setup - 1'b1;
               act_q <= times.active;
               rec_q <= times.recover;
            end
            PH_SETUP: if (cnt == '0) begin
               phase <= PH_ACTIVE;
               cnt   <= act_q - 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
            PH_ACTIVE: if (cnt != '0) begin
               cnt <= cnt - 1'b1;
            end else if (ready) begin
               phase <= PH_RECOVER;
               cnt   <= rec_q - 1'b1;
            end
            default: if (cnt == '0) begin
               phase <= PH_IDLE;
            end else begin
               cnt <= cnt - 1'b1;
            end
         endcase
      end
   end

   assign busy = (phase != PH_IDLE);

   AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ACTIVE && cnt == '0 && !ready) |=> (phase == PH_ACTIVE)); // R8
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(16)); // R2
   AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && start) |-> (times.active >= CNT_W'(2) && times.active <= CNT_W'(16))); // R3
   AST_RECOVER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RECOVER) |=> (phase == PH_RECOVER || phase == PH_IDLE)); // R9
endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
   import pio_timer_pkg::*;
#(
   parameter int DRIVES   = 4,
   parameter bit IORDY_EN = 1'b1,
   localparam int DRV_W   = $clog2(DRIVES)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [DRV_W-1:0] req_drive,
   input  logic             req_write,
   input  logic             req_data,
   input  logic             map_by_pair,
   input  logic [7:0]       cmd_timing,
   input  logic [7:0]       set0_addr,
   input  logic [7:0]       set0_rw,
   input  logic [7:0]       set1_addr,
   input  logic [7:0]       set1_rw,
   input  logic             iordy,
   output logic             busy,
   output logic             rd_strobe,
   output logic             wr_strobe,
   output logic [DRV_W-1:0] cyc_drive
);
   generate
      if (DRIVES != 4) begin : g_bad_drives
         $error("pio_cycle_timer expects four drives");
      end
   endgenerate

   cyc_times_t times;
   phase_t     phase;
   logic       start;
   logic       ready_s;
   logic       write_q;
   logic [7:0] set_addr [2];
   logic [7:0] set_rw   [2];

   assign set_addr[0] = set0_addr;
   assign set_addr[1] = set1_addr;
   assign set_rw[0]   = set0_rw;
   assign set_rw[1]   = set1_rw;

   generate
      if (IORDY_EN) begin : g_iordy
         assign ready_s = iordy;
      end else begin : g_no_iordy
         assign ready_s = 1'b1;
      end
   endgenerate

   assign start = req_valid && !busy;

   pio_timing_select #(.DRIVES(DRIVES), .SETS(2)) u_sel (
      .drive       (req_drive),
      .write       (req_write),
      .data_port   (req_data),
      .map_by_pair (map_by_pair),
      .cmd_timing  (cmd_timing),
      .set_addr    (set_addr),
      .set_rw      (set_rw),
      .times       (times)
   );

   pio_phase_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .times (times),
      .ready (ready_s),
      .phase (phase),
      .busy  (busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         write_q   <= 1'b0;
         cyc_drive <= '0;
      end else if (start) begin
         write_q   <= req_write;
         cyc_drive <= req_drive;
      end
   end

   assign rd_strobe = (phase == PH_ACTIVE) && !write_q;
   assign wr_strobe = (phase == PH_ACTIVE) &&  write_q;

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_strobe && wr_strobe)); // R10
   AST_STROBE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe || wr_strobe) |-> busy); // R10
   AST_DRIVE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cyc_drive)); // R10
   AST_NO_STROBE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> (busy && !rd_strobe && !wr_strobe)); // R2
endmodule

// File: tb/pio_cycle_timer_bench.sv
module pio_cycle_timer_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_drive = '0;
   logic       req_write = 1'b0;
   logic       req_data = 1'b0;
   logic       map_by_pair = 1'b0;
   logic [7:0] cmd_timing = '0;
   logic [7:0] set0_addr = '0, set0_rw = '0, set1_addr = '0, set1_rw = '0;
   logic       iordy = 1'b1;
   logic       busy, rd_strobe, wr_strobe;
   logic [1:0] cyc_drive;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc_cnt  = 0;

   pio_cycle_timer u_pio_cycle_timer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_drive(req_drive),
      .req_write(req_write), .req_data(req_data), .map_by_pair(map_by_pair),
      .cmd_timing(cmd_timing), .set0_addr(set0_addr), .set0_rw(set0_rw),
      .set1_addr(set1_addr), .set1_rw(set1_rw), .iordy(iordy),
      .busy(busy), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .cyc_drive(cyc_drive)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 150000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got %0d cycles exp <= 150000", cyc_cnt);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   task automatic check(input string req, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d exp %0d", req, got, exp);
      end
   endtask

   // expected tables written from the requirements
   function automatic int t_setup(input logic [1:0] c);
      int tbl[4] = '{3, 1, 2, 4};
      return tbl[c];
   endfunction
   function automatic int t_act(input logic [3:0] c);
      if (c == 0) return 16;
      if (c == 1 || c == 2) return 2;
      return int'(c);
   endfunction
   function automatic int t_cmdrec(input logic [3:0] c);
      return (c == 0) ? 16 : int'(c);
   endfunction
   function automatic int t_datrec(input logic [3:0] c, input logic w);
      if (c == 0) return 16;
      if (c == 1 || c == 2) return w ? 5 : 4;
      return int'(c) + 2;
   endfunction

   task automatic run_cycle(input logic [1:0] drv, input logic wr, input logic dat,
                            input int stall, input bit spurious);
      int s_n = 0, a_n = 0, r_n = 0, k = 0, guard = 0;
      int sel, e_s, e_a, e_r;
      bit drv_ok = 1, dir_ok = 1;
      logic [7:0] ab, rb;
      sel = map_by_pair ? int'(drv[1]) : int'(drv[0]);          // R7
      ab  = sel ? set1_addr : set0_addr;
      rb  = sel ? set1_rw : set0_rw;
      e_s = t_setup(ab[7:6]);
      if (dat) begin                                             // R6
         e_a = t_act(wr ? rb[3:0] : rb[7:4]);
         e_r = t_datrec(ab[3:0], wr);
      end else begin
         e_a = t_act(cmd_timing[7:4]);
         e_r = t_cmdrec(cmd_timing[3:0]);
      end
      if (e_a < stall + 1) e_a = stall + 1;                      // R8 stretch
      @(negedge clk);
      req_drive = drv; req_write = wr; req_data = dat; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R2 busy after accept", int'(busy), 1);
      while (busy && guard < 200) begin
         guard++;
         if (spurious && guard == 2) begin
            req_valid = 1'b1; req_drive = ~drv; req_write = ~wr;
         end
         if (spurious && guard == 4) req_valid = 1'b0;
         if (cyc_drive != drv) drv_ok = 0;
         if (rd_strobe || wr_strobe) begin
            a_n++; k++;
            if (rd_strobe != !wr || wr_strobe != wr) dir_ok = 0;
            iordy = (k <= stall) ? 1'b0 : 1'b1;
         end else begin
            iordy = 1'b1;
            if (a_n == 0) s_n++; else r_n++;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      iordy = 1'b1;
      check("R2 setup clocks", s_n, e_s);
      check(dat ? "R3 data active clocks" : "R3 command active clocks", a_n, e_a);
      check(dat ? "R4 data recovery clocks" : "R5 command recovery clocks", r_n, e_r);
      check("R10 drive stable and direction", int'(drv_ok && dir_ok), 1);
      @(negedge clk);
      check("R9 no cycle from ignored request", int'(busy), 0);
   endtask

   initial begin
      void'($urandom(32'd7213));
      repeat (3) @(negedge clk);
      check("R1 busy reset", int'(busy), 0);
      check("R1 rd reset", int'(rd_strobe), 0);
      check("R1 wr reset", int'(wr_strobe), 0);
      rst_n = 1'b1;

      // directed: every setup code, edge active/recovery codes
      cmd_timing = 8'h00;
      set0_addr = 8'h01; set0_rw = 8'h12;
      set1_addr = 8'h42; set1_rw = 8'h21;
      run_cycle(2'd0, 1'b0, 1'b1, 0, 0);   // R4 code 1 read -> 4
      run_cycle(2'd0, 1'b1, 1'b1, 0, 0);   // R4 code 1 write -> 5
      run_cycle(2'd1, 1'b1, 1'b1, 0, 0);   // R4 code 2 write, R2 code 01
      run_cycle(2'd1, 1'b0, 1'b0, 0, 0);   // R3/R5 code 0 -> 16
      set0_addr = 8'h83; set1_addr = 8'hCF; cmd_timing = 8'h31;
      run_cycle(2'd2, 1'b0, 1'b1, 0, 0);   // R7 map 0: drive 2 -> set 0
      run_cycle(2'd3, 1'b1, 1'b1, 0, 0);   // R4 code 15 -> 17
      run_cycle(2'd3, 1'b0, 1'b0, 0, 1);   // R9 spurious ignored
      map_by_pair = 1'b1;
      run_cycle(2'd1, 1'b0, 1'b1, 0, 0);   // R7 map 1: drive 1 -> set 0
      run_cycle(2'd2, 1'b1, 1'b1, 0, 0);   // R7 map 1: drive 2 -> set 1
      run_cycle(2'd0, 1'b0, 1'b0, 9, 0);   // R8 stall beyond active
      run_cycle(2'd0, 1'b1, 1'b1, 1, 0);   // R8 short stall hidden
      set0_addr = 8'h00; set0_rw = 8'h00;
      run_cycle(2'd0, 1'b0, 1'b1, 0, 0);   // R3/R4 code 0 -> 16

      // constrained random
      for (int i = 0; i < 80; i++) begin
         cmd_timing  = 8'($urandom);
         set0_addr   = 8'($urandom); set0_rw = 8'($urandom);
         set1_addr   = 8'($urandom); set1_rw = 8'($urandom);
         map_by_pair = 1'($urandom);
         run_cycle(2'($urandom), 1'($urandom), 1'($urandom),
                   (($urandom % 4) == 0) ? int'($urandom % 20) : 0,
                   bit'(($urandom % 3) == 0));
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule